// File: doc/BRIEF.md
# Codec-Side Serial Frame Engine for a Five-Slot Audio Link

This block is the bit-level front end of an audio codec attached to a 12.288 MHz serial link with a 48 kHz frame marker. It runs from the link bit clock. It finds the start of each frame from the rising edge of the frame marker. On the inbound data line it collects the tag slot, the control address slot, the control data slot and the two playback sample slots. It samples that line on falling clock edges. It hands the collected fields to the register and converter logic with a one-cycle completion pulse.

In the other direction it assembles an outbound frame from parallel inputs: codec ready, per-slot valid flags, the echoed register index, the two sample-request flags, the read data and the two record samples. Those inputs are captured once, when the frame starts. The frame is then shifted out MSB first, one bit launched on each rising edge. Register decoding, conversion, clock generation and reset detection all sit in neighbouring blocks.

Top module: `acl_frame_engine`

## Requirements
- R1: A frame starts at the rising clock edge where `sync` is seen high after being low at the previous rising edge. At that same edge the first tag bit is launched on `sdata_in`, and `frame_start` is high for the following clock period.
- R2: Inbound bits are captured on falling edges, starting at the falling edge right after the start edge. Inbound tag bit 15 gives `rx_frame_valid`. Tag bits 14, 13, 12 and 11 give the address, data, left and right valid outputs. All four valid outputs are forced low when bit 15 is clear.
- R3: Inbound slot 1 bit 19 gives `rx_write` (1 = write) and slot 1 bits 18:12 give `rx_index`. Inbound slot 2 bits 19:4 give `rx_wdata`.
- R4: `rx_left` and `rx_right` are bits 19:2 of inbound slots 3 and 4. Slot bits 1:0 are ignored.
- R5: `frame_done` goes high for exactly one clock period, starting at the falling edge that captures the 96th bit of the frame (the last bit of slot 4). It happens once per frame. All `rx_*` fields hold their values until the next such pulse.
- R6: Outbound tag bit 15 carries `tx_ready`. Bits 14, 13, 12 and 11 carry the address, data, left and right valid inputs. Bits 10:0 are zero.
- R7: Outbound slot 1 has bit 19 at zero and bits 18:12 set to `tx_index` (zero when the address valid input is low). Bit 11 is the inverse of `tx_want_left` and bit 10 is the inverse of `tx_want_right`. All other bits are zero.
- R8: Outbound slot 2 bits 19:4 carry `tx_rdata`. Outbound slots 3 and 4 carry `tx_left` and `tx_right` in bits 19:2. Each of these slots is all zero when its valid input is low.
- R9: Every outbound bit after slot 4 (slots 5 to 12, and idle time) is zero. Changing the `tx_*` inputs after the start edge has no effect on the frame being sent.
- R10: While `rst_n` is low, `sdata_in`, `frame_done`, `frame_start` and every `rx_*` output are zero.
- R11: A new `sync` rising edge in the middle of a frame restarts both bit counters. The cut-off frame produces no `frame_done`, and the new frame is received and sent correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker, changes after rising edges |
| sdata_out | input | 1 | Inbound serial data from the controller |
| sdata_in | output | 1 | Outbound serial data to the controller |
| frame_start | output | 1 | High for one period after a frame start edge |
| frame_done | output | 1 | One-period pulse when inbound slots 0 to 4 are complete |
| rx_frame_valid | output | 1 | Inbound frame valid tag |
| rx_addr_valid | output | 1 | Inbound control address slot valid |
| rx_data_valid | output | 1 | Inbound control data slot valid |
| rx_left_valid | output | 1 | Inbound left playback slot valid |
| rx_right_valid | output | 1 | Inbound right playback slot valid |
| rx_write | output | 1 | 1 = write access, 0 = read |
| rx_index | output | 7 | Register index |
| rx_wdata | output | 16 | Write data |
| rx_left | output | 18 | Left playback sample |
| rx_right | output | 18 | Right playback sample |
| tx_ready | input | 1 | Codec ready flag |
| tx_addr_valid | input | 1 | Outbound slot 1 valid |
| tx_data_valid | input | 1 | Outbound slot 2 valid |
| tx_left_valid | input | 1 | Outbound slot 3 valid |
| tx_right_valid | input | 1 | Outbound slot 4 valid |
| tx_want_left | input | 1 | Request a left sample in the next frame |
| tx_want_right | input | 1 | Request a right sample in the next frame |
| tx_index | input | 7 | Echoed register index |
| tx_rdata | input | 16 | Register read data |
| tx_left | input | 18 | Left record sample |
| tx_right | input | 18 | Right record sample |

## Verification
Let E0 be the rising edge after which the bench raises `sync`. The start edge is then E1. Outbound bit j is launched at edge E(1+j), so the bench reads it just after the falling edge of that period. Inbound bit j is driven just after E(1+j) and captured at the falling edge that follows, so `frame_done` is due after the falling edge following E96 and must be low one period later. The bench counts bit periods from E0 in a single loop. It samples `sdata_in` 5 ns after each rising edge and the `rx_*` outputs 6 ns after it, so each reading lands at the cycle worked out above and well clear of any clock edge.

// File: rtl/acl_pkg.sv
package acl_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int N_SLOTS    = 12;
  localparam int USED_SLOTS = 4;
  localparam int PCM_W      = 18;
  localparam int IDX_W      = 7;
  localparam int REG_W      = 16;
  localparam int FRAME_BITS = TAG_W + N_SLOTS * SLOT_W;
  localparam int USED_BITS  = TAG_W + USED_SLOTS * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_LSB    = 12;
  localparam int REQ_L_BIT  = 11;
  localparam int REQ_R_BIT  = 10;

  typedef struct packed {
    logic              frame_ok;
    logic              addr_ok;
    logic              data_ok;
    logic              left_ok;
    logic              right_ok;
    logic              wr;
    logic [IDX_W-1:0]  idx;
    logic [REG_W-1:0]  wdata;
    logic [PCM_W-1:0]  left;
    logic [PCM_W-1:0]  right;
  } rx_fields_t;

  typedef struct packed {
    logic              ready;
    logic              addr_ok;
    logic              data_ok;
    logic              left_ok;
    logic              right_ok;
    logic              want_left;
    logic              want_right;
    logic [IDX_W-1:0]  idx;
    logic [REG_W-1:0]  rdata;
    logic [PCM_W-1:0]  left;
    logic [PCM_W-1:0]  right;
  } tx_fields_t;

  // slot n (1..USED_SLOTS) of a frame held MSB-first
  function automatic logic [SLOT_W-1:0] slot_of(input logic [USED_BITS-1:0] f, input int n);
    return f[USED_BITS - TAG_W - 1 - (n - 1) * SLOT_W -: SLOT_W];
  endfunction

  function automatic rx_fields_t decode_frame(input logic [USED_BITS-1:0] f);
    rx_fields_t r;
    logic [TAG_W-1:0] tag;
    tag        = f[USED_BITS-1 -: TAG_W];
    r.frame_ok = tag[TAG_W-1];
    r.addr_ok  = tag[TAG_W-1] & tag[TAG_W-2];
    r.data_ok  = tag[TAG_W-1] & tag[TAG_W-3];
    r.left_ok  = tag[TAG_W-1] & tag[TAG_W-4];
    r.right_ok = tag[TAG_W-1] & tag[TAG_W-5];
    r.wr       = slot_of(f, 1)[SLOT_W-1];
    r.idx      = slot_of(f, 1)[IDX_LSB +: IDX_W];
    r.wdata    = slot_of(f, 2)[SLOT_W-1 -: REG_W];
    r.left     = slot_of(f, 3)[SLOT_W-1 -: PCM_W];
    r.right    = slot_of(f, 4)[SLOT_W-1 -: PCM_W];
    return r;
  endfunction

  function automatic logic [USED_BITS-1:0] encode_frame(input tx_fields_t t);
    logic [TAG_W-1:0]  tag;
    logic [SLOT_W-1:0] s1, s2, s3, s4;
    tag = '0;
    tag[TAG_W-1] = t.ready;
    tag[TAG_W-2] = t.addr_ok;
    tag[TAG_W-3] = t.data_ok;
    tag[TAG_W-4] = t.left_ok;
    tag[TAG_W-5] = t.right_ok;
    s1 = '0;
    if (t.addr_ok) s1[IDX_LSB +: IDX_W] = t.idx;
    s1[REQ_L_BIT] = ~t.want_left;
    s1[REQ_R_BIT] = ~t.want_right;
    s2 = t.data_ok  ? {t.rdata, {(SLOT_W-REG_W){1'b0}}} : '0;
    s3 = t.left_ok  ? {t.left,  {(SLOT_W-PCM_W){1'b0}}} : '0;
    s4 = t.right_ok ? {t.right, {(SLOT_W-PCM_W){1'b0}}} : '0;
    return {tag, s1, s2, s3, s4};
  endfunction
endpackage

// File: rtl/acl_sync_edge.sv
module acl_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync,
  output logic start_now,
  output logic start_p
);
  logic sync_q;

  assign start_now = sync & ~sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      start_p <= 1'b0;
    end else begin
      sync_q  <= sync;
      start_p <= start_now;
    end
  end
endmodule

// File: rtl/acl_tx.sv
module acl_tx
  import acl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_now,
  input  tx_fields_t       fields,
  output logic             sdata_in,
  output logic [CNT_W-1:0] tx_cnt
);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(FRAME_BITS);

  logic [USED_BITS-1:0] frame_w;
  logic [USED_BITS-1:0] sh;

  assign frame_w = encode_frame(fields);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_in <= 1'b0;
      sh       <= '0;
      tx_cnt   <= CNT_IDLE;
    end else if (start_now) begin
      sdata_in <= frame_w[USED_BITS-1];
      sh       <= {frame_w[USED_BITS-2:0], 1'b0};
      tx_cnt   <= '0;
    end else begin
      sdata_in <= sh[USED_BITS-1];
      sh       <= {sh[USED_BITS-2:0], 1'b0};
      if (tx_cnt < CNT_IDLE) tx_cnt <= tx_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/acl_rx.sv
module acl_rx
  import acl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_p,
  input  logic             sdata_out,
  output rx_fields_t       fields,
  output logic             done,
  output logic [CNT_W-1:0] rx_cnt
);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(USED_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_USED = CNT_W'(USED_BITS);

  logic [USED_BITS-2:0] sh;
  logic                 last_bit;

  assign last_bit = !start_p && (rx_cnt == CNT_LAST);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      fields <= '0;
      done   <= 1'b0;
      rx_cnt <= CNT_IDLE;
    end else begin
      done <= last_bit;
      if (start_p)               rx_cnt <= CNT_W'(1);
      else if (rx_cnt < CNT_IDLE) rx_cnt <= rx_cnt + CNT_W'(1);
      if (start_p || rx_cnt < CNT_USED) sh <= {sh[USED_BITS-3:0], sdata_out};
      if (last_bit) fields <= decode_frame({sh, sdata_out});
    end
  end
endmodule

// File: rtl/acl_frame_engine.sv
module acl_frame_engine
  import acl_pkg::*;
(
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             sdata_out,
  output logic             sdata_in,
  output logic             frame_start,
  output logic             frame_done,
  output logic             rx_frame_valid,
  output logic             rx_addr_valid,
  output logic             rx_data_valid,
  output logic             rx_left_valid,
  output logic             rx_right_valid,
  output logic             rx_write,
  output logic [6:0]       rx_index,
  output logic [15:0]      rx_wdata,
  output logic [17:0]      rx_left,
  output logic [17:0]      rx_right,
  input  logic             tx_ready,
  input  logic             tx_addr_valid,
  input  logic             tx_data_valid,
  input  logic             tx_left_valid,
  input  logic             tx_right_valid,
  input  logic             tx_want_left,
  input  logic             tx_want_right,
  input  logic [6:0]       tx_index,
  input  logic [15:0]      tx_rdata,
  input  logic [17:0]      tx_left,
  input  logic [17:0]      tx_right
);
  logic             start_now;
  logic [CNT_W-1:0] tx_cnt;
  logic [CNT_W-1:0] rx_cnt;
  rx_fields_t       rx_f;
  tx_fields_t       tx_f;

  assign tx_f = '{ready: tx_ready, addr_ok: tx_addr_valid, data_ok: tx_data_valid,
                  left_ok: tx_left_valid, right_ok: tx_right_valid,
                  want_left: tx_want_left, want_right: tx_want_right,
                  idx: tx_index, rdata: tx_rdata, left: tx_left, right: tx_right};

  acl_sync_edge edge_i (
    .clk(bclk), .rst_n(rst_n), .sync(sync),
    .start_now(start_now), .start_p(frame_start)
  );

  acl_tx tx_i (
    .clk(bclk), .rst_n(rst_n), .start_now(start_now), .fields(tx_f),
    .sdata_in(sdata_in), .tx_cnt(tx_cnt)
  );

  acl_rx rx_i (
    .clk(bclk), .rst_n(rst_n), .start_p(frame_start), .sdata_out(sdata_out),
    .fields(rx_f), .done(frame_done), .rx_cnt(rx_cnt)
  );

  assign rx_frame_valid = rx_f.frame_ok;
  assign rx_addr_valid  = rx_f.addr_ok;
  assign rx_data_valid  = rx_f.data_ok;
  assign rx_left_valid  = rx_f.left_ok;
  assign rx_right_valid = rx_f.right_ok;
  assign rx_write       = rx_f.wr;
  assign rx_index       = rx_f.idx;
  assign rx_wdata       = rx_f.wdata;
  assign rx_left        = rx_f.left;
  assign rx_right       = rx_f.right;
endmodule

// File: rtl/acl_frame_chk.sv
module acl_frame_chk
  import acl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sdata_in,
  input logic             frame_done,
  input logic             start_now,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             frame_valid,
  input logic [3:0]       slot_valid
);
  // R1
  restart_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_now |=> (tx_cnt == '0));

  // R9
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt >= CNT_W'(USED_BITS)) |-> !sdata_in);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R5
  done_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (rx_cnt == CNT_W'(USED_BITS)));

  // R2
  flags_need_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid != 4'b0) |-> frame_valid);

  // R10
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sdata_in && !frame_done && !frame_valid);
    end
  end
endmodule

bind acl_frame_engine acl_frame_chk chk_i (
  .clk(bclk), .rst_n(rst_n), .sdata_in(sdata_in), .frame_done(frame_done),
  .start_now(start_now), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .frame_valid(rx_frame_valid),
  .slot_valid({rx_addr_valid, rx_data_valid, rx_left_valid, rx_right_valid})
);

// File: tb/acl_frame_engine_tb_top.sv
module acl_frame_engine_tb_top;
  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic sdata_out = 1'b0;
  logic sdata_in, frame_start, frame_done;
  logic rx_frame_valid, rx_addr_valid, rx_data_valid, rx_left_valid, rx_right_valid, rx_write;
  logic [6:0] rx_index;
  logic [15:0] rx_wdata;
  logic [17:0] rx_left, rx_right;
  logic tx_ready = 0, tx_addr_valid = 0, tx_data_valid = 0, tx_left_valid = 0;
  logic tx_right_valid = 0, tx_want_left = 0, tx_want_right = 0;
  logic [6:0] tx_index = '0;
  logic [15:0] tx_rdata = '0;
  logic [17:0] tx_left = '0, tx_right = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 bclk = ~bclk;

  acl_frame_engine dut_i (.*);

  // vector: [43:39] inbound tag (fv,av,dv,lv,rv) [38:32] outbound flags
  // (ready,av,dv,lv,rv,want_l,want_r) [31:0] data seed
  localparam logic [43:0] VT [6] = '{
    {5'b11111, 7'b1111111, 32'hA5C3_9E71},
    {5'b01111, 7'b1000000, 32'h1234_5678},
    {5'b11010, 7'b1101010, 32'hFFFF_FFFF},
    {5'b10101, 7'b0010101, 32'h0000_0001},
    {5'b11100, 7'b1011001, 32'h8000_7FFE},
    {5'b10000, 7'b0000000, 32'h5A5A_C3C3}
  };

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_out(input logic [4:0] t, input logic [31:0] s);
    logic [255:0] v;
    v = '0;
    v[255:251] = t;
    v[239] = s[31];
    v[238:232] = s[6:0];
    v[219:204] = s[22:7];
    v[199:182] = s[17:0];
    v[181:180] = 2'b11;
    v[179:162] = s[31:14];
    v[161:160] = 2'b10;
    v[159:0] = {5{s}};
    return v;
  endfunction

  function automatic logic [255:0] exp_tx(input logic [6:0] f, input logic [31:0] s);
    logic [255:0] e;
    e = '0;
    e[255] = f[6];
    e[254:251] = f[5:2];
    if (f[5]) e[238:232] = s[13:7];
    e[231] = ~f[1];
    e[230] = ~f[0];
    if (f[4]) e[219:204] = s[31:16];
    if (f[3]) e[199:182] = s[25:8];
    if (f[2]) e[179:162] = ~s[17:0];
    return e;
  endfunction

  task automatic set_tx(input logic [6:0] f, input logic [31:0] s);
    {tx_ready, tx_addr_valid, tx_data_valid, tx_left_valid, tx_right_valid,
     tx_want_left, tx_want_right} = f;
    tx_index = s[13:7];
    tx_rdata = s[31:16];
    tx_left  = s[25:8];
    tx_right = ~s[17:0];
  endtask

  task automatic drive_bits(input logic [255:0] ob, input int nk, output logic [255:0] got,
                            output int dn, output int dk, output int fk);
    got = '0; dn = 0; dk = -1; fk = -1;
    for (int k = 0; k < nk; k++) begin
      @(posedge bclk); #1;
      sync = (k < 16);
      sdata_out = (k >= 1 && k <= 256) ? ob[256-k] : 1'b0;
      #4;
      if (k >= 1 && k <= 256) got[256-k] = sdata_in;
      #1;
      if (frame_done) begin dn++; if (dk < 0) dk = k; end
      if (frame_start && fk < 0) fk = k;
    end
  endtask

  task automatic check_rx(input string tag, input logic [4:0] t, input logic [31:0] s);
    logic fv;
    fv = t[4];
    chk({"R2 flags ", tag}, 256'({rx_frame_valid, rx_addr_valid, rx_data_valid, rx_left_valid, rx_right_valid}),
        256'({fv, fv & t[3], fv & t[2], fv & t[1], fv & t[0]}));
    chk({"R3 wr/index ", tag}, 256'({rx_write, rx_index}), 256'({s[31], s[6:0]}));
    chk({"R3 wdata ", tag}, 256'(rx_wdata), 256'(s[22:7]));
    chk({"R4 pcm ", tag}, 256'({rx_left, rx_right}), 256'({s[17:0], s[31:14]}));
  endtask

  task automatic check_tx(input string tag, input logic [255:0] got, input logic [255:0] e);
    chk({"R6 tag slot ", tag}, 256'(got[255:240]), 256'(e[255:240]));
    chk({"R7 slot1 ", tag}, 256'(got[239:220]), 256'(e[239:220]));
    chk({"R8 slots2-4 ", tag}, 256'(got[219:160]), 256'(e[219:160]));
    chk({"R9 tail zero ", tag}, 256'(got[159:0]), 256'(0));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!finished) $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] got, got2;
    int dn, dk, fk;
    logic [43:0] v;

    // R10 reset state
    repeat (3) @(posedge bclk);
    #6;
    chk("R10 reset outputs", 256'({sdata_in, frame_done, frame_start, rx_frame_valid, rx_index, rx_left}), 256'(0));
    @(posedge bclk); #1 rst_n = 1'b1;
    repeat (4) @(posedge bclk);
    #5 chk("R9 idle sdata_in", 256'(sdata_in), 256'(0));

    for (int i = 0; i < 6; i++) begin
      v = VT[i];
      set_tx(v[38:32], v[31:0]);
      drive_bits(mk_out(v[43:39], v[31:0]), 257, got, dn, dk, fk);
      chk($sformatf("R1 frame_start period v%0d", i), 256'(fk), 256'(1));
      chk($sformatf("R5 done once at bit 96 v%0d", i), 256'({dn[7:0], dk[7:0]}), 256'({8'd1, 8'd96}));
      check_rx($sformatf("v%0d", i), v[43:39], v[31:0]);
      check_tx($sformatf("v%0d", i), got, exp_tx(v[38:32], v[31:0]));
    end

    // R9 tx inputs changed after the start edge are ignored
    v = VT[0];
    set_tx(v[38:32], v[31:0]);
    fork
      drive_bits(mk_out(v[43:39], v[31:0]), 257, got, dn, dk, fk);
      begin repeat (3) @(posedge bclk); #2 set_tx(7'b0000000, 32'h0F0F_0F0F); end
    join
    chk("R9 mid-frame input change ignored", got, exp_tx(v[38:32], v[31:0]));

    // R11 restart in the middle of a frame
    set_tx(VT[3][38:32], VT[3][31:0]);
    drive_bits(mk_out(VT[3][43:39], VT[3][31:0]), 50, got, dn, dk, fk);
    chk("R11 cut frame gives no done", 256'(dn), 256'(0));
    set_tx(VT[2][38:32], VT[2][31:0]);
    drive_bits(mk_out(VT[2][43:39], VT[2][31:0]), 257, got2, dn, dk, fk);
    chk("R11 restarted frame done at bit 96", 256'({dn[7:0], dk[7:0]}), 256'({8'd1, 8'd96}));
    check_rx("R11 restart", VT[2][43:39], VT[2][31:0]);
    check_tx("R11 restart", got2, exp_tx(VT[2][38:32], VT[2][31:0]));

    // R10 reset in the middle of a frame
    v = VT[0];
    set_tx(v[38:32], v[31:0]);
    fork
      drive_bits(mk_out(v[43:39], v[31:0]), 40, got, dn, dk, fk);
      begin repeat (20) @(posedge bclk); #2 rst_n = 1'b0; end
    join
    #1;
    chk("R10 mid-frame reset", 256'({sdata_in, frame_done, rx_frame_valid, rx_addr_valid, rx_wdata, rx_right}), 256'(0));
    @(posedge bclk); #1 rst_n = 1'b1;
    repeat (2) @(posedge bclk);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule